// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies two 32-bit operands over several clock cycles. One multiplier byte is consumed per iteration, and iterating stops as soon as the remaining upper bits of the multiplier are only a sign or zero extension. It has four forms:

- a 32-bit product;
- a 32-bit product plus an accumulator;
- a 64-bit product;
- a 64-bit product plus a 64-bit accumulator.

The 64-bit forms can treat their operands as signed or unsigned. The latency therefore depends on the magnitude of the multiplier operand (`op_b`), and a fixed number of cycles is added for the accumulate and long forms.

A request is offered with `start_valid` and is taken on a rising edge where both `start_valid` and `start_ready` are high. `start_ready` is high only while the block is idle, so a request held during a computation waits and is taken after `done`. There is no back-pressure on the result side. `done` pulses for one cycle when the result becomes valid, and `result` keeps that value until the next operation completes.

Top module: `mulit_core`

## Requirements
- R1: The iteration count m is 1 if `op_b[31:8]` is uniform, else 2 if `op_b[31:16]` is uniform, else 3 if `op_b[31:24]` is uniform, else 4. Uniform means all zeros or all ones, except for an unsigned 64-bit form (`op[1]`=1, `sgn`=0), where only all zeros counts.
- R2: With `op`=2'b00, `result[31:0]` is the low word of `op_a*op_b` and `result[63:32]` is zero. `done` rises m cycles after acceptance.
- R3: With `op`=2'b01, `result[31:0]` is `(op_a*op_b + acc_in[31:0])` modulo 2^32 and `result[63:32]` is zero. `done` rises m+1 cycles after acceptance.
- R4: With `op`=2'b10, `result` is the full 64-bit product, signed when `sgn`=1 and unsigned when `sgn`=0. `done` rises m+1 cycles after acceptance.
- R5: An unsigned 64-bit form whose multiplier has ones in its upper bits runs four iterations and still yields the correct unsigned product.
- R6: With `op`=2'b11, `result` is the 64-bit product plus `acc_in`, modulo 2^64. `done` rises m+2 cycles after acceptance.
- R7: `done` is high for exactly one cycle per operation. "N cycles after acceptance" means `done` is high in the cycle that follows the Nth rising edge after the accepting edge.
- R8: `start_ready` is low from the cycle after acceptance until `done`. A `start_valid` offered in that window, with other operands, has no effect on the running result.
- R9: `result` holds its value from `done` until the next operation completes.
- R10: After reset, `start_ready`=1, `done`=0 and `result`=0.
- R11: For the 32-bit forms (`op[1]`=0), `sgn` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request offered |
| start_ready | output | 1 | Block idle, request can be taken |
| op | input | 2 | Form: 00 mul32, 01 mul32+acc, 10 mul64, 11 mul64+acc |
| sgn | input | 1 | Signed operands for the 64-bit forms |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier; its upper bits set the iteration count |
| acc_in | input | 64 | Accumulator; only the low word is used by op 01 |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 64 | Product or accumulated product |

## Verification
A wrong iteration count appears at once as `done` arriving one or more cycles away from the m rule. A stale shift register or a dropped sign correction appears as a wrong `result` in that same `done` cycle. Errors in the sign fill are exposed by multipliers that are uniform above a byte boundary but have the opposite value in the top bit of the processed byte. Unsigned 64-bit operands with upper ones are also used, because a wrong early stop on them gives a product that differs in its high word. Requests offered while the block is busy would corrupt the next result or shorten the measured latency, so they are checked within the same operation.

// File: rtl/mulit_pkg.sv
package mulit_pkg;

  localparam logic [1:0] OPC_MUL  = 2'b00;
  localparam logic [1:0] OPC_MLA  = 2'b01;
  localparam logic [1:0] OPC_MULL = 2'b10;
  localparam logic [1:0] OPC_MLAL = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ITER = 2'd1,
    PH_FIX  = 2'd2,
    PH_ACC  = 2'd3
  } phase_e;

  function automatic logic op_is_long(input logic [1:0] opc);
    return opc[1];
  endfunction

  function automatic logic op_has_acc(input logic [1:0] opc);
    return opc[0];
  endfunction

endpackage

// File: rtl/mulit_term_detect.sv
module mulit_term_detect #(
  parameter int XLEN = 32,
  parameter int DW   = 8,
  localparam int NDIG = XLEN / DW,
  localparam int CW   = $clog2(NDIG + 1)
) (
  input  logic [XLEN-1:0] mplier,
  input  logic            allow_ones,
  output logic [CW-1:0]   m_out,
  output logic            fill
);

  logic [NDIG-1:0] hit;

  assign hit[NDIG-1] = 1'b1;

  for (genvar k = 1; k < NDIG; k++) begin : g_chk
    logic all_zero, all_one;
    assign all_zero = ~|mplier[XLEN-1:k*DW];
    assign all_one  = &mplier[XLEN-1:k*DW];
    assign hit[k-1] = all_zero | (allow_ones & all_one);
  end

  always_comb begin
    m_out = CW'(NDIG);
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (hit[i]) m_out = CW'(i + 1);
    end
  end

  assign fill = allow_ones & mplier[XLEN-1];

endmodule

// File: rtl/mulit_digit_step.sv
module mulit_digit_step #(
  parameter int XLEN = 32,
  parameter int DW   = 8,
  localparam int PW  = 2 * XLEN,
  localparam int DGW = DW + 2
) (
  input  logic [PW-1:0] mcand_sh,
  input  logic [DW-1:0] dbyte,
  input  logic          neg_top,
  output logic [PW-1:0] term
);

  localparam logic [DGW-1:0] TOP_WEIGHT = DGW'(1) << DW;

  logic [DGW-1:0] digit;
  logic [PW-1:0]  dext;

  always_comb begin
    digit = {2'b00, dbyte} - (neg_top ? TOP_WEIGHT : '0);
    dext  = {{(PW - DGW){digit[DGW-1]}}, digit};
    term  = mcand_sh * dext;
  end

endmodule

// File: rtl/mulit_seq.sv
module mulit_seq
  import mulit_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int DW   = 8,
  localparam int NDIG = XLEN / DW,
  localparam int CW   = $clog2(NDIG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_in,
  input  logic [CW-1:0] m_in,
  output phase_e        phase,
  output logic [1:0]    op_q,
  output logic          last_iter,
  output logic          finish,
  output logic          ready,
  output logic          done
);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] idx_q, m_q;
  logic          done_q;

  assign phase     = phase_q;
  assign ready     = (phase_q == PH_IDLE);
  assign done      = done_q;
  assign last_iter = (phase_q == PH_ITER) && (idx_q == m_q - CW'(1));

  always_comb begin
    phase_d = phase_q;
    finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_ITER;
      PH_ITER: if (last_iter) begin
        if (op_is_long(op_q))      phase_d = PH_FIX;
        else if (op_has_acc(op_q)) phase_d = PH_ACC;
        else begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      PH_FIX: begin
        if (op_has_acc(op_q)) phase_d = PH_ACC;
        else begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      PH_ACC: begin
        phase_d = PH_IDLE;
        finish  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      m_q     <= CW'(1);
      op_q    <= OPC_MUL;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= finish;
      if (phase_q == PH_IDLE && start) begin
        idx_q <= '0;
        m_q   <= m_in;
        op_q  <= op_in;
      end else if (phase_q == PH_ITER) begin
        idx_q <= idx_q + CW'(1);
      end
    end
  end

  p_iter_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ITER) |-> (idx_q < m_q));

  p_long_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_iter && op_is_long(op_q)) |=> (phase_q == PH_FIX));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/mulit_core.sv
module mulit_core
  import mulit_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int DW   = 8,
  localparam int NDIG = XLEN / DW,
  localparam int CW   = $clog2(NDIG + 1),
  localparam int PW   = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_valid,
  output logic            start_ready,
  input  logic [1:0]      op,
  input  logic            sgn,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [PW-1:0]   acc_in,
  output logic            done,
  output logic [PW-1:0]   result
);

  logic            accept, allow_ones, fill_in, fill_q;
  logic [CW-1:0]   m_in;
  phase_e          phase;
  logic [1:0]      op_q;
  logic            last_iter, finish;
  logic [PW-1:0]   sum_q, sum_d, mcand_q, acc_q, term, res_q;
  logic [XLEN-1:0] mplier_q;

  assign accept     = start_valid & start_ready;
  assign allow_ones = ~(op_is_long(op) & ~sgn);

  mulit_term_detect #(.XLEN(XLEN), .DW(DW)) u_det (
    .mplier     (op_b),
    .allow_ones (allow_ones),
    .m_out      (m_in),
    .fill       (fill_in)
  );

  mulit_seq #(.XLEN(XLEN), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .op_in     (op),
    .m_in      (m_in),
    .phase     (phase),
    .op_q      (op_q),
    .last_iter (last_iter),
    .finish    (finish),
    .ready     (start_ready),
    .done      (done)
  );

  mulit_digit_step #(.XLEN(XLEN), .DW(DW)) u_step (
    .mcand_sh (mcand_q),
    .dbyte    (mplier_q[DW-1:0]),
    .neg_top  (last_iter & ~op_is_long(op_q) & fill_q),
    .term     (term)
  );

  always_comb begin
    sum_d = sum_q;
    unique case (phase)
      PH_ITER: sum_d = sum_q + term;
      PH_FIX:  if (fill_q) sum_d = sum_q - mcand_q;
      PH_ACC:  sum_d = sum_q + acc_q;
      default: sum_d = sum_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      fill_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      if (accept) begin
        sum_q    <= '0;
        mcand_q  <= (op_is_long(op) & sgn) ? {{XLEN{op_a[XLEN-1]}}, op_a}
                                           : {{XLEN{1'b0}}, op_a};
        mplier_q <= op_b;
        acc_q    <= op_is_long(op) ? acc_in : {{XLEN{1'b0}}, acc_in[XLEN-1:0]};
        fill_q   <= fill_in;
      end else begin
        sum_q <= sum_d;
        if (phase == PH_ITER) begin
          mcand_q  <= mcand_q << DW;
          mplier_q <= mplier_q >> DW;
        end
      end
      if (finish) begin
        res_q <= op_is_long(op_q) ? sum_d : {{XLEN{1'b0}}, sum_d[XLEN-1:0]};
      end
    end
  end

  assign result = res_q;

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !start_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ready && !start_valid) |=> $stable(result));

  p_unsigned_nofill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op[1] && !sgn) |=> !fill_q);

  p_short_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q[1]) |-> (result[PW-1:XLEN] == '0));

endmodule

// File: tb/mulit_core_test.sv
module mulit_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [1:0]  op = 2'b00;
  logic        sgn = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [63:0] acc_in = '0;
  logic        done;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mulit_core uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .op(op), .sgn(sgn), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .done(done), .result(result)
  );

  function automatic int exp_m(input logic [1:0] o, input bit s, input logic [31:0] b);
    bit ones_ok;
    ones_ok = !(o[1] && !s);
    for (int k = 1; k < 4; k++) begin
      logic [31:0] up;
      up = b >> (8 * k);
      if (up == 0) return k;
      if (ones_ok && (up == (32'hFFFF_FFFF >> (8 * k)))) return k;
    end
    return 4;
  endfunction

  function automatic int exp_lat(input logic [1:0] o, input bit s, input logic [31:0] b);
    int extra;
    case (o)
      2'b00: extra = 0;
      2'b01: extra = 1;
      2'b10: extra = 1;
      default: extra = 2;
    endcase
    return exp_m(o, s, b) + extra;
  endfunction

  function automatic logic [63:0] exp_res(input logic [1:0] o, input bit s,
      input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
    logic [63:0] p, ea, eb;
    ea = (o[1] && s) ? {{32{a[31]}}, a} : {32'b0, a};
    eb = (o[1] && s) ? {{32{b[31]}}, b} : {32'b0, b};
    p = ea * eb;
    case (o)
      2'b00: return {32'b0, p[31:0]};
      2'b01: return {32'b0, p[31:0] + acc[31:0]};
      2'b10: return p;
      default: return p + acc;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic string req_of(input logic [1:0] o);
    case (o)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input bit s, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc, input bit poke);
    int n, lat;
    logic [63:0] ex;
    n  = exp_lat(o, s, b);
    ex = exp_res(o, s, a, b, acc);
    @(negedge clk);
    check("R8 ready idle", {63'b0, start_ready}, 64'd1);
    start_valid = 1'b1; op = o; sgn = s; op_a = a; op_b = b; acc_in = acc;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    if (poke && n >= 2) begin
      check("R8 ready low busy", {63'b0, start_ready}, 64'd0);
      start_valid = 1'b1; op = ~o; sgn = ~s; op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; acc_in = ~acc;
    end
    lat = 0;
    for (int g = 0; g < 12; g++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_valid = 1'b0;
      if (done) break;
    end
    check("R1 R7 latency", 64'(lat), 64'(n));
    check(req_of(o), result, ex);
    @(negedge clk);
    check("R7 done one cycle", {63'b0, done}, 64'd0);
    check("R9 result held", result, ex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 ready", {63'b0, start_ready}, 64'd1);
    check("R10 done", {63'b0, done}, 64'd0);
    check("R10 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", result, 64'd0);

    // R1 boundaries: each m for each form
    run_op(2'b00, 1'b0, 32'h1234_5678, 32'h0000_00FF, 64'd0, 1'b0);
    run_op(2'b00, 1'b0, 32'h1234_5678, 32'h0000_0100, 64'd0, 1'b0);
    run_op(2'b00, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FF00, 64'd0, 1'b0);
    run_op(2'b00, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FE7F, 64'd0, 1'b0);
    run_op(2'b01, 1'b0, 32'hFFFF_FFFF, 32'h00FF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b1);
    run_op(2'b01, 1'b1, 32'h8000_0000, 32'h8000_0000, 64'h1111_2222_3333_4444, 1'b1);
    run_op(2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b1);
    run_op(2'b10, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFF0, 64'd0, 1'b0);
    // R5: unsigned long with upper ones runs all four iterations
    run_op(2'b10, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFF0, 64'd0, 1'b1);
    run_op(2'b11, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    run_op(2'b11, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1);
    run_op(2'b11, 1'b1, 32'h0000_0003, 32'hFFFF_0080, 64'd5, 1'b0);
    // R11: sgn does not change 32-bit forms
    run_op(2'b00, 1'b0, 32'hF000_000F, 32'hFFFF_8001, 64'd0, 1'b0);
    run_op(2'b00, 1'b1, 32'hF000_000F, 32'hFFFF_8001, 64'd0, 1'b0);
    run_op(2'b01, 1'b0, 32'hA5A5_A5A5, 32'hFF80_0000, 64'd77, 1'b0);
    run_op(2'b01, 1'b1, 32'hA5A5_A5A5, 32'hFF80_0000, 64'd77, 1'b0);
    run_op(2'b00, 1'b0, 32'h0, 32'h0, 64'd0, 1'b1);

    for (int t = 0; t < 400; t++) begin
      logic [31:0] a, b, r, mask;
      logic [63:0] acc;
      logic [1:0]  o;
      int k;
      a = $urandom; r = $urandom; acc = {$urandom, $urandom};
      o = 2'($urandom);
      k = int'($urandom % 4);
      mask = (k == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (k + 1))) - 1);
      b = r & mask;
      if ($urandom % 2) b = b | ~mask;
      run_op(o, 1'($urandom), a, b, acc, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule